// File: doc/BRIEF.md
# On-Screen Display Serial Command Decoder

This block is the control front end of a character overlay engine. A host sends 8-bit words over a three-wire serial link made of an active-low select, a clock and a data line. The block assembles the words and interprets them as commands. Each command starts with a header word and may be followed by any number of payload words. The commands set the display-memory write position, store character codes with an attribute bit into a ROWS x COLS display memory, and load six small configuration banks. The banks hold the vertical and horizontal position and size, the display control, the sync mode, the sync detection and the port settings. The block exports these banks unchanged to the video timing and pixel logic.

The command named by the last header word stays in force, so a run of payload words keeps updating the same bank. The character-write command is different: once it is received, every following word, including one with the top bit set, is a character code. Only raising the select line leaves this mode, and doing so also returns the decoder to address setup. The display-control header can also start a memory fill with code 0xFF, which writes one location per clock, and it can start a soft reset of all registers. The display logic reads the memory through a registered read port.

Top module: `osd_cmd_decoder`

## Requirements
- R1: While ser_cs_n is low, ser_dat is shifted in MSB first on each rising edge of ser_clk, and every 8 bits form one word. Clock edges while ser_cs_n is high are ignored, and raising ser_cs_n discards a partly received word.
- R2: A word with bit 7 = 1 is a header whose bits 6:4 give the command number. A word with bit 7 = 0 is payload. The last command number stays in force, and each further payload word is applied to that command again.
- R3: Command 0 (address setup): the header bits 3:0 load the write row, and a payload word's bits 4:0 load the write column.
- R4: Command 1 (character write): the header bit 0 is the attribute. From then on every word, whatever its bit 7, is stored as an 8-bit character code, and no header is decoded until ser_cs_n goes high.
- R5: A high level on ser_cs_n returns the decoder to command 0 and leaves character-write mode, so the next payload word sets the column.
- R6: Each character write stores {attribute, code} at location row*COLS+column. The column then advances. After column COLS-1 it wraps to 0 and the row increments, and row ROWS-1 wraps to row 0.
- R7: A character write while the row is at or above ROWS, or the column at or above COLS, changes no memory location and leaves the write position unchanged.
- R8: Commands 2 to 7 have a bank n: header bits 3:0 load cfg_head[(n-2)*4 +: 4], and each payload word's bits 6:0 load cfg_body[(n-2)*7 +: 7]. For command 4, header bits 1:0 are actions and are stored as 0.
- R9: A command-4 header with bit 1 set fills every location with 9'h0FF (attribute 0, code 0xFF), one location per clock. erase_busy is high for exactly ROWS*COLS cycles, starting the cycle after the word is decoded. Character writes that arrive while it is high are dropped, and the write position does not advance.
- R10: A command-4 header with bit 0 set clears cfg_head, cfg_body (this includes the display-on bit, cfg_body bit 14), the write position and the attribute. Memory contents are kept.
- R11: A low rst_n at a clock edge clears every register: cfg_head and cfg_body read 0, erase_busy is 0, rd_data is 0 and the decoder is in command 0.
- R12: rd_data shows the location at (rd_row, rd_col) one clock after the address is applied. It reads 0 when the address is outside ROWS x COLS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial inputs are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_cs_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| rd_row | input | 4 | Read row address |
| rd_col | input | 5 | Read column address |
| rd_data | output | 9 | Registered read data {attribute, code} |
| erase_busy | output | 1 | High while the memory fill runs |
| cfg_head | output | 24 | Header nibbles of banks 2..7 |
| cfg_body | output | 42 | Payload fields of banks 2..7 |

## Verification
A word's last bit is captured at one clock edge. The decoded result (bank register, write position, memory location) is updated at the next edge, so any word takes effect two edges after its final rising ser_clk. The bench holds every serial level for two clocks and waits three more cycles after each word before it samples a bank. Read data is due one edge after the address, so the bench drives the address on a falling edge and samples on the next falling edge. erase_busy is counted on falling edges from the fill header onward, and a character write placed inside that window checks that the write is dropped.

// File: rtl/osd_cmd_pkg.sv
// Shared constants and the command encoding of the serial command decoder.
// Assumes 8-bit serial words; header fields sit at fixed bit positions.
package osd_cmd_pkg;
    localparam int BYTE_W     = 8;   // serial word width
    localparam int HEAD_W     = 4;   // header nibble stored per bank
    localparam int BODY_W     = 7;   // payload field stored per bank
    localparam int COL_FLD_W  = 5;   // column field of an address payload
    localparam int NCFG       = 6;   // banks for commands 2..7
    localparam int CFG_BASE   = 2;   // first command with a bank
    localparam int HEAD_SRST  = 0;   // display header: soft reset action
    localparam int HEAD_ERASE = 1;   // display header: memory fill action
    localparam logic [HEAD_W-1:0] DISP_HEAD_KEEP = 4'b1100;
    localparam logic [BYTE_W-1:0] FILL_CODE      = 8'hFF;

    typedef enum logic [2:0] {
        CMD_ADDR = 3'd0,
        CMD_CHAR = 3'd1,
        CMD_VERT = 3'd2,
        CMD_HORZ = 3'd3,
        CMD_DISP = 3'd4,
        CMD_SYNC = 3'd5,
        CMD_DET  = 3'd6,
        CMD_PORT = 3'd7
    } osd_cmd_e;
endpackage

// File: rtl/osd_ser_rx.sv
// Serial word assembler. Samples ser_dat MSB first on each rising edge of
// ser_clk seen in the clk domain while cs_n is low; emits a one-cycle
// word_vld with the assembled word. Assumes the serial inputs are already
// synchronous to clk and that ser_clk stays at each level >= 1 clk cycle.
module osd_ser_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdat,
    output logic [WORD_W-1:0] word,
    output logic              word_vld
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic              sclk_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] shift_nx;

    assign shift_nx = {shift_q[WORD_W-2:0], sdat};

    // Edge detection, bit shifting and word completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            bit_cnt  <= '0;
            shift_q  <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            word_vld <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sclk && !sclk_q) begin
                shift_q <= shift_nx;
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt  <= '0;
                    word     <= shift_nx;
                    word_vld <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/osd_cmd_ctl.sv
// Command interpreter. Tracks the sticky command and the character-write
// lock, the write position and attribute, the configuration banks, and
// issues memory writes and the fill/soft-reset actions.
// Assumes one word per word_vld pulse; cs_n high overrides any word.
module osd_cmd_ctl
    import osd_cmd_pkg::*;
#(
    parameter int ROWS   = 12,
    parameter int COLS   = 24,
    parameter int ADDR_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic [BYTE_W-1:0]        word,
    input  logic                     word_vld,
    input  logic                     busy,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [BYTE_W:0]          wr_data,
    output logic                     erase_go,
    output logic [2:0]               cmd_state,
    output logic                     locked,
    output logic [NCFG*HEAD_W-1:0]   cfg_head,
    output logic [NCFG*BODY_W-1:0]   cfg_body
);
    localparam logic [HEAD_W-1:0]    ROW_LIM  = HEAD_W'(ROWS);
    localparam logic [HEAD_W-1:0]    ROW_LAST = HEAD_W'(ROWS - 1);
    localparam logic [COL_FLD_W-1:0] COL_LIM  = COL_FLD_W'(COLS);
    localparam logic [COL_FLD_W-1:0] COL_LAST = COL_FLD_W'(COLS - 1);
    localparam logic [ADDR_W-1:0]    COLS_A   = ADDR_W'(COLS);

    osd_cmd_e              cmd_q;
    osd_cmd_e              cmd_in;
    logic                  lock_q;
    logic [HEAD_W-1:0]     row_q;
    logic [COL_FLD_W-1:0]  col_q;
    logic                  attr_q;
    logic                  is_head;
    logic                  is_data;
    logic                  in_range;
    logic                  char_go;
    logic                  soft_rst;

    assign cmd_in   = osd_cmd_e'(word[BYTE_W-2 -: 3]);
    assign is_head  = word_vld && word[BYTE_W-1] && !lock_q;
    assign is_data  = word_vld && !is_head;
    assign in_range = (row_q < ROW_LIM) && (col_q < COL_LIM);
    assign char_go  = is_data && (cmd_q == CMD_CHAR) && in_range && !busy;
    assign soft_rst = is_head && (cmd_in == CMD_DISP) && word[HEAD_SRST];
    assign erase_go = is_head && (cmd_in == CMD_DISP) && word[HEAD_ERASE];

    assign wr_en     = char_go;
    assign wr_addr   = ADDR_W'(row_q) * COLS_A + ADDR_W'(col_q);
    assign wr_data   = {attr_q, word};
    assign cmd_state = cmd_q;
    assign locked    = lock_q;

    // Sticky command register and character-write lock.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            cmd_q  <= CMD_ADDR;
            lock_q <= 1'b0;
        end else if (is_head) begin
            cmd_q  <= cmd_in;
            lock_q <= (cmd_in == CMD_CHAR);
        end
    end

    // Write position, attribute and post-write advance.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            row_q  <= '0;
            col_q  <= '0;
            attr_q <= 1'b0;
        end else if (is_head && cmd_in == CMD_ADDR) begin
            row_q <= word[HEAD_W-1:0];
        end else if (is_head && cmd_in == CMD_CHAR) begin
            attr_q <= word[0];
        end else if (is_data && cmd_q == CMD_ADDR) begin
            col_q <= word[COL_FLD_W-1:0];
        end else if (char_go) begin
            if (col_q == COL_LAST) begin
                col_q <= '0;
                row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // One header/payload register pair per configuration command.
    for (genvar g = 0; g < NCFG; g++) begin : g_bank
        localparam osd_cmd_e MY = osd_cmd_e'(g + CFG_BASE);
        localparam logic [HEAD_W-1:0] KEEP =
            (MY == CMD_DISP) ? DISP_HEAD_KEEP : {HEAD_W{1'b1}};
        logic [HEAD_W-1:0] head_q;
        logic [BODY_W-1:0] body_q;

        // Load this bank from its header and payload words.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                head_q <= '0;
                body_q <= '0;
            end else if (is_head && cmd_in == MY) begin
                head_q <= word[HEAD_W-1:0] & KEEP;
            end else if (is_data && cmd_q == MY) begin
                body_q <= word[BODY_W-1:0];
            end
        end

        assign cfg_head[g*HEAD_W +: HEAD_W] = head_q;
        assign cfg_body[g*BODY_W +: BODY_W] = body_q;
    end
endmodule

// File: rtl/osd_vram.sv
// Display memory with a fill sequencer and a registered read port.
// The fill owns the write port while it runs (one location per clock);
// the caller must gate its own writes with busy. Contents are not reset.
module osd_vram #(
    parameter int DEPTH  = 288,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 9,
    parameter logic [DATA_W-1:0] FILL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ok,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] fill_idx;

    // Fill sequencer: start, step and finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            fill_idx <= '0;
        end else if (erase_go && !busy) begin
            busy     <= 1'b1;
            fill_idx <= '0;
        end else if (busy) begin
            if (fill_idx == LAST) busy <= 1'b0;
            fill_idx <= fill_idx + 1'b1;
        end
    end

    // Storage write: the fill has priority over character writes.
    always_ff @(posedge clk) begin
        if (busy) mem[fill_idx] <= FILL;
        else if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read port, zero outside the array.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else rd_data <= rd_ok ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/osd_cmd_decoder.sv
// Top of the serial command decoder: word assembler, command interpreter
// and display memory. Assumes serial inputs synchronous to clk.
module osd_cmd_decoder
    import osd_cmd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_cs_n,
    input  logic                     ser_clk,
    input  logic                     ser_dat,
    input  logic [HEAD_W-1:0]        rd_row,
    input  logic [COL_FLD_W-1:0]     rd_col,
    output logic [BYTE_W:0]          rd_data,
    output logic                     erase_busy,
    output logic [NCFG*HEAD_W-1:0]   cfg_head,
    output logic [NCFG*BODY_W-1:0]   cfg_body
);
    localparam int DEPTH  = ROWS * COLS;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [HEAD_W-1:0]    ROW_LIM = HEAD_W'(ROWS);
    localparam logic [COL_FLD_W-1:0] COL_LIM = COL_FLD_W'(COLS);
    localparam logic [ADDR_W-1:0]    COLS_A  = ADDR_W'(COLS);

    logic [BYTE_W-1:0] w_word;
    logic              w_vld;
    logic              w_we;
    logic [ADDR_W-1:0] w_waddr;
    logic [BYTE_W:0]   w_wdata;
    logic              w_erase;
    logic [2:0]        w_cmd;
    logic              w_lock;
    logic [ADDR_W-1:0] w_raddr;
    logic              w_rok;

    assign w_raddr = ADDR_W'(rd_row) * COLS_A + ADDR_W'(rd_col);
    assign w_rok   = (rd_row < ROW_LIM) && (rd_col < COL_LIM);

    osd_ser_rx #(.WORD_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(ser_cs_n), .sclk(ser_clk),
        .sdat(ser_dat), .word(w_word), .word_vld(w_vld)
    );

    osd_cmd_ctl #(.ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .cs_n(ser_cs_n), .word(w_word),
        .word_vld(w_vld), .busy(erase_busy), .wr_en(w_we),
        .wr_addr(w_waddr), .wr_data(w_wdata), .erase_go(w_erase),
        .cmd_state(w_cmd), .locked(w_lock),
        .cfg_head(cfg_head), .cfg_body(cfg_body)
    );

    osd_vram #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(BYTE_W + 1),
               .FILL({1'b0, FILL_CODE})) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(w_we), .wr_addr(w_waddr),
        .wr_data(w_wdata), .erase_go(w_erase), .rd_addr(w_raddr),
        .rd_ok(w_rok), .rd_data(rd_data), .busy(erase_busy)
    );
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
// Protocol and sequencing checks for osd_cmd_decoder, attached by bind.
module osd_cmd_decoder_chk #(
    parameter int DEPTH  = 288,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_cs_n,
    input logic              word_vld,
    input logic [2:0]        cmd_now,
    input logic              locked,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              erase_go,
    input logic              erase_busy
);
    localparam int CW = $clog2(DEPTH + 1) + 1;
    localparam logic [CW-1:0]   DEPTH_C = CW'(DEPTH);
    localparam logic [ADDR_W:0] DEPTH_A = (ADDR_W + 1)'(DEPTH);

    logic [CW-1:0] busy_cnt;

    // Length of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !erase_busy) busy_cnt <= '0;
        else busy_cnt <= busy_cnt + 1'b1;
    end

    p_word_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);
    p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !ser_cs_n) |=> locked);
    p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |=> (cmd_now == 3'd0 && !locked));
    p_wr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < DEPTH_A));
    p_no_wr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> !mem_we);
    p_erase_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |-> (busy_cnt == DEPTH_C));
    p_erase_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> $past(erase_go));
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .word_vld(w_vld),
    .cmd_now(w_cmd), .locked(w_lock), .mem_we(w_we), .mem_addr(w_waddr),
    .erase_go(w_erase), .erase_busy(erase_busy)
);

// File: tb/osd_cmd_decoder_bench.sv
module osd_cmd_decoder_bench;
    localparam int ROWS = 12;
    localparam int COLS = 24;
    localparam int DEPTH = ROWS * COLS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_cs_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic [3:0]  rd_row = '0;
    logic [4:0]  rd_col = '0;
    logic [8:0]  rd_data;
    logic        erase_busy;
    logic [23:0] cfg_head;
    logic [41:0] cfg_body;

    int n_chk = 0;
    int n_err = 0;
    int busy_cyc = 0;
    bit done = 1'b0;

    logic [8:0]  exp_mem [DEPTH];
    logic [23:0] exp_head = '0;
    logic [41:0] exp_body = '0;
    int m_row = 0;
    int m_col = 0;
    logic m_attr = 1'b0;
    bit m_busy = 1'b0;

    always #4 clk = ~clk;

    osd_cmd_decoder u_osd_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data), .erase_busy(erase_busy),
        .cfg_head(cfg_head), .cfg_body(cfg_body)
    );

    always @(negedge clk) if (erase_busy) busy_cyc++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            ser_dat = b[i];
            ser_clk = 1'b0;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (2) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        put_bits(b, 8);
    endtask

    task automatic cs_low();
        @(negedge clk) ser_cs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_high();
        ser_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Expected effect of one character word (R6, R7, R9).
    task automatic model_char(input logic [7:0] code);
        if (!m_busy && m_row < ROWS && m_col < COLS) begin
            exp_mem[m_row * COLS + m_col] = {m_attr, code};
            if (m_col == COLS - 1) begin
                m_col = 0;
                m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
            end else m_col++;
        end
    endtask

    task automatic set_addr(input int r, input int c);
        cs_low();
        put_byte({4'h8, 4'(r)});
        put_byte({3'b000, 5'(c)});
        cs_high();
        m_row = r;
        m_col = c;
    endtask

    task automatic write_chars(input logic attr, input int n);
        cs_low();
        put_byte({7'b1001000, attr});
        m_attr = attr;
        for (int i = 0; i < n; i++) begin
            logic [7:0] code;
            code = 8'($urandom);
            put_byte(code);
            model_char(code);
        end
        cs_high();
    endtask

    task automatic set_cfg(input int n, input logic [3:0] head, input logic [6:0] body);
        cs_low();
        put_byte({1'b1, 3'(n), head});
        put_byte({1'b0, body});
        cs_high();
        exp_head[(n - 2) * 4 +: 4] = (n == 4) ? (head & 4'hC) : head;
        exp_body[(n - 2) * 7 +: 7] = body;
    endtask

    task automatic read_at(input int r, input int c, output logic [8:0] v);
        @(negedge clk);
        rd_row = 4'(r);
        rd_col = 5'(c);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic chk_loc(input string req, input int r, input int c);
        logic [8:0] v;
        read_at(r, c, v);
        chk(req, 64'(v), 64'(exp_mem[r * COLS + c]));
    endtask

    task automatic chk_cfg(input string req);
        chk(req, 64'(cfg_head), 64'(exp_head));
        chk(req, 64'(cfg_body), 64'(exp_body));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [8:0] v;
        void'($urandom(32'h05D1_2024));
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 9'h0FF;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11", 64'(cfg_head), 64'h0);
        chk("R11", 64'(cfg_body), 64'h0);
        chk("R11", 64'(erase_busy), 64'h0);
        chk("R11", 64'(rd_data), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: fill, with a character write dropped during it
        set_addr(4, 4);
        busy_cyc = 0;
        cs_low();
        put_byte(8'hC2);
        cs_high();
        m_busy = 1'b1;
        write_chars(1'b0, 1);
        chk("R9", 64'(erase_busy), 64'h1);
        while (erase_busy) @(negedge clk);
        m_busy = 1'b0;
        chk("R9", 64'(busy_cyc), 64'(DEPTH));
        cs_low();
        put_byte(8'h90);
        put_byte(8'h66);
        model_char(8'h66);
        cs_high();
        chk_loc("R9", 4, 4);
        chk("R9", 64'(exp_mem[4 * COLS + 4]), 64'h066);
        chk_loc("R9", 4, 5);
        chk_loc("R9", 0, 0);
        chk_loc("R9", 11, 23);

        // R6: column and row wrap
        set_addr(0, 22);
        write_chars(1'b1, 3);
        chk_loc("R6", 0, 22);
        chk_loc("R6", 0, 23);
        chk_loc("R6", 1, 0);
        set_addr(11, 23);
        write_chars(1'b0, 2);
        chk_loc("R6", 11, 23);
        chk_loc("R6", 0, 0);

        // R4: lock keeps header-looking words as data
        set_addr(6, 0);
        cs_low();
        put_byte(8'h91);
        m_attr = 1'b1;
        put_byte(8'hA5);
        model_char(8'hA5);
        put_byte(8'h8A);
        model_char(8'h8A);
        cs_high();
        read_at(6, 0, v);
        chk("R4", 64'(v), 64'h1A5);
        read_at(6, 1, v);
        chk("R4", 64'(v), 64'h18A);
        chk_cfg("R4");

        // R5: select release returns to address setup
        cs_low();
        put_byte(8'h07);
        cs_high();
        m_col = 7;
        write_chars(1'b0, 1);
        chk_loc("R5", 6, 7);
        read_at(6, 2, v);
        chk("R5", 64'(v), 64'h0FF);

        // R7: out-of-range writes ignored, position held
        set_addr(13, 3);
        write_chars(1'b1, 1);
        cs_low();
        put_byte(8'h82);
        cs_high();
        m_row = 2;
        cs_low();
        put_byte(8'h90);
        put_byte(8'h44);
        m_attr = 1'b0;
        model_char(8'h44);
        cs_high();
        read_at(2, 3, v);
        chk("R7", 64'(v), 64'h044);
        set_addr(1, 30);
        write_chars(1'b0, 2);
        // R12: out-of-range read
        read_at(12, 0, v);
        chk("R12", 64'(v), 64'h0);
        read_at(3, 24, v);
        chk("R12", 64'(v), 64'h0);

        // R2: sticky command, last payload wins
        cs_low();
        put_byte(8'hA3);
        put_byte(8'h11);
        put_byte(8'h2A);
        cs_high();
        exp_head[3:0] = 4'h3;
        exp_body[6:0] = 7'h2A;
        chk_cfg("R2");

        // R1: partial word discarded on select release
        cs_low();
        put_bits(8'hA0, 3);
        cs_high();
        set_cfg(3, 4'h5, 7'h33);
        chk_cfg("R1");

        // R8: display bank keeps only bits 3:2 of its header
        set_cfg(4, 4'hC, 7'h01);
        chk_cfg("R8");
        set_cfg(5, 4'h9, 7'h55);
        set_cfg(6, 4'h6, 7'h7F);
        set_cfg(7, 4'hF, 7'h2C);
        chk_cfg("R8");

        // R3, R6, R8: constrained random mix
        for (int k = 0; k < 40; k++) begin
            int op;
            op = $urandom_range(0, 2);
            if (op == 0) set_addr($urandom_range(0, ROWS - 1), $urandom_range(0, COLS - 1));
            else if (op == 1) write_chars(1'($urandom_range(0, 1)), $urandom_range(1, 4));
            else begin
                int n;
                logic [3:0] h;
                n = $urandom_range(2, 7);
                h = 4'($urandom);
                if (n == 4) h = h & 4'hC;
                set_cfg(n, h, 7'($urandom));
                chk_cfg("R8");
            end
        end
        // R3, R6: whole memory against the model
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) chk_loc("R3", r, c);

        // R10: soft reset clears registers, keeps memory
        cs_low();
        put_byte(8'hC1);
        cs_high();
        exp_head = '0;
        exp_body = '0;
        m_row = 0;
        m_col = 0;
        m_attr = 1'b0;
        chk_cfg("R10");
        cs_low();
        put_byte(8'h90);
        put_byte(8'h77);
        model_char(8'h77);
        cs_high();
        read_at(0, 0, v);
        chk("R10", 64'(v), 64'h077);
        chk_loc("R10", 6, 0);
        chk_loc("R10", 2, 3);

        // R11: hardware reset mid-run
        set_cfg(2, 4'h7, 7'h12);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", 64'(cfg_head), 64'h0);
        chk("R11", 64'(cfg_body), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule